// File: doc/BRIEF.md
# Flash In-System Programming Controller

This block lets software running on the chip read, write and erase its own on-chip flash through a handful of 32-bit registers on a simple register port. Software loads an address, a data word and a 6-bit command code, sets the start bit, and polls until the start bit drops. Commands that touch the array are passed to the flash through a request/acknowledge handshake. Identification commands and the vector-page remap are completed inside the controller without a flash access.

Before an operation is dispatched, the controller checks it against write permissions for three regions: the application region, the loader region and the configuration region. It also checks address legality. A refused operation never reaches the flash. Instead it sets a sticky fail flag that software clears by writing 1 to it. A remap register redirects fetches of the first 512-byte page to any page of the application region.

Top module: `flash_isp_ctrl`

## Requirements
- R1: After reset, the control register (offset 0x00) reads 0 except bit 1, which equals the inverse of `cfgBoot[1]`. The start bit (offset 0x10 bit 0, mirrored at status offset 0x40 bit 0), the fail flag, the remap page and the address (0x04), data (0x08) and command (0x0C) registers are all 0.
- R2: While the enable bit (control bit 0) is 0, writing 1 to the trigger register is ignored: the start bit stays 0 and no flash request is made.
- R3: When enabled, writing 1 to trigger bit 0 sets the start bit, which also reads at status bit 0. For a flash command, `flReq` is held with stable `flOp` and `flAddr` until `flAck`, and the start bit reads 0 from the cycle after the acknowledge.
- R4: Command 0x00 (read) issues `flOp`=0 at the address register and loads `flRdata` into the data register. Command 0x21 (program) issues `flOp`=1 with the data register on `flWdata`.
- R5: Command 0x22 (erase) issues `flOp`=2 with `flAddr` equal to the address register with bits [8:0] cleared.
- R6: Command 0x0B loads 0x000000DA into the data register, and command 0x04 loads the `UID_WORD` parameter. Neither makes a flash request.
- R7: A program or erase that targets the application region [0, `APP_BYTES`) fails when `runFromLoader` is 0 and either the application update enable (control bit 3) is 0 or `cfgBoot[0]` is 1. From the loader it is permitted.
- R8: A program or erase that targets the loader region fails when `runFromLoader` is 1 and either the loader update enable (control bit 5) is 0 or `cfgBoot[0]` is 1.
- R9: A program or erase that targets the configuration region fails when the configuration update enable (control bit 4) is 0.
- R10: An operation fails when a read or program address has bits [1:0] not equal to 00, when the address lies in no region, or when the command code is not one of the six listed here.
- R11: A failed operation makes no flash request, clears the start bit in the next cycle and sets the fail flag, which reads at control bit 6 and status bit 6. The flag stays set until 1 is written to bit 6 of either register; writing 0 there leaves it set.
- R12: Command 0x2E stores address bits [20:9] as the remap page, which reads at status bits [20:9]. A `fetchAddr` below 0x200 then maps to {page, `fetchAddr`[8:0]}, and any other address passes through unchanged. A remap target outside the application region fails and leaves the page unchanged.
- R13: While the start bit is 1, writes to the address, data and command registers are ignored.
- R14: Offset 0x14 reads `DATA_BASE` and ignores writes. Status bits [2:1] mirror `cfgBoot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational, 0 when not reading) |
| cfgBoot | input | 2 | Configured boot selection; bit 0 locks self-update |
| runFromLoader | input | 1 | 1 = code currently executes from the loader region |
| fetchAddr | input | 32 | Fetch address to translate |
| fetchMapAddr | output | 32 | Fetch address after page remap |
| flReq | output | 1 | Flash request, held until acknowledged |
| flOp | output | 2 | Flash operation: 0 read, 1 program, 2 erase |
| flAddr | output | 32 | Flash byte address |
| flWdata | output | 32 | Flash program data |
| flAck | input | 1 | Flash acknowledge, one cycle |
| flRdata | input | 32 | Flash read data, valid with `flAck` |

## Verification
The hardest case to reach is a register write that arrives while an operation is still in flight. To create it, the flash model holds its acknowledge back for several cycles, and the bench writes new address, data and command values between the trigger and the acknowledge. It then checks that the flash saw the original values and that the registers read back unchanged. The permission checks need the code-location and boot-config inputs to be changed between operations after reset. The bench steps through each region with each enable and lock combination and compares the request count before and after every refused operation.

// File: rtl/flash_isp_pkg.sv
package flash_isp_pkg;

  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_ADDR  = 8'h04;
  localparam logic [7:0] OFS_DATA  = 8'h08;
  localparam logic [7:0] OFS_CMD   = 8'h0C;
  localparam logic [7:0] OFS_TRIG  = 8'h10;
  localparam logic [7:0] OFS_DBASE = 8'h14;
  localparam logic [7:0] OFS_STAT  = 8'h40;

  localparam logic [5:0] CMD_READ  = 6'h00;
  localparam logic [5:0] CMD_UID   = 6'h04;
  localparam logic [5:0] CMD_VID   = 6'h0B;
  localparam logic [5:0] CMD_PROG  = 6'h21;
  localparam logic [5:0] CMD_ERASE = 6'h22;
  localparam logic [5:0] CMD_REMAP = 6'h2E;

  localparam logic [7:0] VENDOR_CODE = 8'hDA;
  localparam int unsigned PAGE_LSB = 9;

  typedef enum logic [1:0] {
    FL_READ  = 2'd0,
    FL_PROG  = 2'd1,
    FL_ERASE = 2'd2
  } flOp_e;

  typedef enum logic {
    ST_IDLE,
    ST_WAIT
  } ctlState_e;

  typedef struct packed {
    logic finish;
    logic setFail;
    logic loadFlash;
    logic loadVendor;
    logic loadUid;
    logic loadRemap;
  } ctlStrobe_t;

endpackage

// File: rtl/flash_isp_regs.sv
module flash_isp_regs
  import flash_isp_pkg::*;
#(
  parameter int unsigned PAGE_W    = 12,
  parameter logic [31:0] UID_WORD  = 32'h5A3C_0F96,
  parameter logic [31:0] DATA_BASE = 32'h0000_0800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [1:0]        cfgBoot,
  input  logic [31:0]       fetchAddr,
  output logic [31:0]       fetchMapAddr,
  input  ctlStrobe_t        stb,
  input  logic [31:0]       flRdata,
  output logic              goBit,
  output logic              ispEn,
  output logic              appUpdEn,
  output logic              cfgUpdEn,
  output logic              ldrUpdEn,
  output logic              failFlag,
  output logic [31:0]       addrReg,
  output logic [31:0]       dataReg,
  output logic [5:0]        cmdReg,
  output logic [PAGE_W-1:0] remapPage
);

  localparam int unsigned HI_W = 32 - PAGE_LSB - PAGE_W;

  logic wrStb, rdStb, bootSel, clrFail;

  assign wrStb   = busSel && busWr;
  assign rdStb   = busSel && !busWr;
  assign clrFail = wrStb && busWdata[6] &&
                   ((busAddr == OFS_CTRL) || (busAddr == OFS_STAT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ispEn     <= 1'b0;
      bootSel   <= ~cfgBoot[1];
      appUpdEn  <= 1'b0;
      cfgUpdEn  <= 1'b0;
      ldrUpdEn  <= 1'b0;
      failFlag  <= 1'b0;
      goBit     <= 1'b0;
      addrReg   <= '0;
      dataReg   <= '0;
      cmdReg    <= '0;
      remapPage <= '0;
    end else begin
      if (wrStb && busAddr == OFS_CTRL) begin
        ispEn    <= busWdata[0];
        bootSel  <= busWdata[1];
        appUpdEn <= busWdata[3];
        cfgUpdEn <= busWdata[4];
        ldrUpdEn <= busWdata[5];
      end
      if (wrStb && !goBit) begin
        if (busAddr == OFS_ADDR) addrReg <= busWdata;
        if (busAddr == OFS_DATA) dataReg <= busWdata;
        if (busAddr == OFS_CMD)  cmdReg  <= busWdata[5:0];
      end
      if (stb.loadFlash)  dataReg <= flRdata;
      if (stb.loadVendor) dataReg <= {24'd0, VENDOR_CODE};
      if (stb.loadUid)    dataReg <= UID_WORD;
      if (stb.loadRemap)  remapPage <= addrReg[PAGE_LSB +: PAGE_W];

      if (stb.finish)
        goBit <= 1'b0;
      else if (wrStb && busAddr == OFS_TRIG && busWdata[0] && ispEn)
        goBit <= 1'b1;

      if (stb.setFail)
        failFlag <= 1'b1;
      else if (clrFail)
        failFlag <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    if (rdStb) begin
      unique case (busAddr)
        OFS_CTRL:  busRdata = {25'd0, failFlag, ldrUpdEn, cfgUpdEn, appUpdEn,
                               1'b0, bootSel, ispEn};
        OFS_ADDR:  busRdata = addrReg;
        OFS_DATA:  busRdata = dataReg;
        OFS_CMD:   busRdata = {26'd0, cmdReg};
        OFS_TRIG:  busRdata = {31'd0, goBit};
        OFS_DBASE: busRdata = DATA_BASE;
        OFS_STAT:  busRdata = {{HI_W{1'b0}}, remapPage, 2'b00, failFlag,
                               3'b000, cfgBoot, goBit};
        default:   busRdata = '0;
      endcase
    end
  end

  assign fetchMapAddr = (fetchAddr[31:PAGE_LSB] == '0)
                      ? {{HI_W{1'b0}}, remapPage, fetchAddr[PAGE_LSB-1:0]}
                      : fetchAddr;

endmodule

// File: rtl/flash_isp_ctl.sv
module flash_isp_ctl
  import flash_isp_pkg::*;
#(
  parameter logic [31:0] APP_BYTES = 32'h0000_1000,
  parameter logic [31:0] LDR_BASE  = 32'h0010_0000,
  parameter logic [31:0] LDR_BYTES = 32'h0000_0800,
  parameter logic [31:0] CFG_BASE  = 32'h0030_0000,
  parameter logic [31:0] CFG_BYTES = 32'h0000_0008
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        goBit,
  input  logic [5:0]  cmdReg,
  input  logic [31:0] addrReg,
  input  logic [31:0] dataReg,
  input  logic        appUpdEn,
  input  logic        cfgUpdEn,
  input  logic        ldrUpdEn,
  input  logic        bootLock,
  input  logic        runFromLoader,
  input  logic        flAck,
  output ctlStrobe_t  stb,
  output logic        flReq,
  output logic [1:0]  flOp,
  output logic [31:0] flAddr,
  output logic [31:0] flWdata
);

  localparam logic [32:0] LDR_END = {1'b0, LDR_BASE} + {1'b0, LDR_BYTES};
  localparam logic [32:0] CFG_END = {1'b0, CFG_BASE} + {1'b0, CFG_BYTES};

  ctlState_e state, nextState;
  logic inApp, inLdr, inCfg, isRead, isProg, isErase, isFlashCmd, isWrite;
  logic wordBad, protFail, failNow;

  assign inApp = addrReg < APP_BYTES;
  assign inLdr = (addrReg >= LDR_BASE) && ({1'b0, addrReg} < LDR_END);
  assign inCfg = (addrReg >= CFG_BASE) && ({1'b0, addrReg} < CFG_END);

  assign isRead     = cmdReg == CMD_READ;
  assign isProg     = cmdReg == CMD_PROG;
  assign isErase    = cmdReg == CMD_ERASE;
  assign isFlashCmd = isRead || isProg || isErase;
  assign isWrite    = isProg || isErase;
  assign wordBad    = (isRead || isProg) && (addrReg[1:0] != 2'b00);

  assign protFail = isWrite && (
      (inApp && !runFromLoader && (!appUpdEn || bootLock)) ||
      (inLdr &&  runFromLoader && (!ldrUpdEn || bootLock)) ||
      (inCfg && !cfgUpdEn));

  always_comb begin
    if (isFlashCmd)
      failNow = !(inApp || inLdr || inCfg) || wordBad || protFail;
    else if (cmdReg == CMD_REMAP)
      failNow = !inApp;
    else
      failNow = !((cmdReg == CMD_UID) || (cmdReg == CMD_VID));
  end

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (goBit) begin
          if (failNow) begin
            stb.finish  = 1'b1;
            stb.setFail = 1'b1;
          end else if (isFlashCmd) begin
            nextState = ST_WAIT;
          end else begin
            stb.finish     = 1'b1;
            stb.loadVendor = cmdReg == CMD_VID;
            stb.loadUid    = cmdReg == CMD_UID;
            stb.loadRemap  = cmdReg == CMD_REMAP;
          end
        end
      end
      ST_WAIT: begin
        if (flAck) begin
          stb.finish    = 1'b1;
          stb.loadFlash = isRead;
          nextState     = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign flReq   = state == ST_WAIT;
  assign flOp    = isErase ? FL_ERASE : (isProg ? FL_PROG : FL_READ);
  assign flAddr  = isErase ? {addrReg[31:PAGE_LSB], {PAGE_LSB{1'b0}}} : addrReg;
  assign flWdata = dataReg;

endmodule

// File: rtl/flash_isp_ctrl.sv
module flash_isp_ctrl
  import flash_isp_pkg::*;
#(
  parameter int unsigned PAGE_W    = 12,
  parameter logic [31:0] APP_BYTES = 32'h0000_1000,
  parameter logic [31:0] LDR_BASE  = 32'h0010_0000,
  parameter logic [31:0] LDR_BYTES = 32'h0000_0800,
  parameter logic [31:0] CFG_BASE  = 32'h0030_0000,
  parameter logic [31:0] CFG_BYTES = 32'h0000_0008,
  parameter logic [31:0] DATA_BASE = 32'h0000_0800,
  parameter logic [31:0] UID_WORD  = 32'h5A3C_0F96
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic [1:0]  cfgBoot,
  input  logic        runFromLoader,
  input  logic [31:0] fetchAddr,
  output logic [31:0] fetchMapAddr,
  output logic        flReq,
  output logic [1:0]  flOp,
  output logic [31:0] flAddr,
  output logic [31:0] flWdata,
  input  logic        flAck,
  input  logic [31:0] flRdata
);

  ctlStrobe_t        stb;
  logic              goBit, ispEn, appUpdEn, cfgUpdEn, ldrUpdEn, failFlag;
  logic [31:0]       addrReg, dataReg;
  logic [5:0]        cmdReg;
  logic [PAGE_W-1:0] remapPage;

  flash_isp_regs #(
    .PAGE_W(PAGE_W), .UID_WORD(UID_WORD), .DATA_BASE(DATA_BASE)
  ) u_regs (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .cfgBoot(cfgBoot), .fetchAddr(fetchAddr), .fetchMapAddr(fetchMapAddr),
    .stb(stb), .flRdata(flRdata), .goBit(goBit), .ispEn(ispEn),
    .appUpdEn(appUpdEn), .cfgUpdEn(cfgUpdEn), .ldrUpdEn(ldrUpdEn),
    .failFlag(failFlag), .addrReg(addrReg), .dataReg(dataReg),
    .cmdReg(cmdReg), .remapPage(remapPage)
  );

  flash_isp_ctl #(
    .APP_BYTES(APP_BYTES), .LDR_BASE(LDR_BASE), .LDR_BYTES(LDR_BYTES),
    .CFG_BASE(CFG_BASE), .CFG_BYTES(CFG_BYTES)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .goBit(goBit), .cmdReg(cmdReg),
    .addrReg(addrReg), .dataReg(dataReg), .appUpdEn(appUpdEn),
    .cfgUpdEn(cfgUpdEn), .ldrUpdEn(ldrUpdEn), .bootLock(cfgBoot[0]),
    .runFromLoader(runFromLoader), .flAck(flAck), .stb(stb),
    .flReq(flReq), .flOp(flOp), .flAddr(flAddr), .flWdata(flWdata)
  );

endmodule

// File: rtl/flash_isp_chk.sv
module flash_isp_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busSel,
  input logic        busWr,
  input logic [7:0]  busAddr,
  input logic        busWdata6,
  input logic        flReq,
  input logic        flAck,
  input logic [1:0]  flOp,
  input logic [31:0] flAddr,
  input logic        goBit,
  input logic        ispEn,
  input logic        failFlag,
  input logic [31:0] addrReg
);

  logic clrWrite;
  assign clrWrite = busSel && busWr && busWdata6 &&
                    ((busAddr == 8'h00) || (busAddr == 8'h40));

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    flReq && !flAck |=> flReq && $stable(flAddr) && $stable(flOp)); // R3

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    flReq && flAck |=> !goBit); // R3

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !goBit |-> !flReq); // R11

  AST_TRIG_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !ispEn && !goBit |=> !goBit); // R2

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    failFlag && !clrWrite |=> failFlag); // R11

  AST_ERASE_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    flReq && flOp == 2'd2 |-> flAddr[8:0] == 9'd0); // R5

  AST_BUSY_ADDR_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    goBit |=> $stable(addrReg)); // R13

endmodule

bind flash_isp_ctrl flash_isp_chk u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
  .busAddr(busAddr), .busWdata6(busWdata[6]), .flReq(flReq),
  .flAck(flAck), .flOp(flOp), .flAddr(flAddr), .goBit(goBit),
  .ispEn(ispEn), .failFlag(failFlag), .addrReg(addrReg)
);

// File: tb/tb_flash_isp_ctrl.sv
module tb_flash_isp_ctrl;

  localparam logic [31:0] UID   = 32'h5A3C_0F96;
  localparam logic [31:0] DBASE = 32'h0000_0800;
  localparam int LAT = 6;

  logic clk = 1'b0, rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [1:0] cfgBoot = 2'b00;
  logic runFromLoader = 1'b0;
  logic [31:0] fetchAddr = '0, fetchMapAddr;
  logic flReq, flAck = 1'b0;
  logic [1:0] flOp;
  logic [31:0] flAddr, flWdata, flRdata = '0;

  int checks = 0, errors = 0, cyc = 0, ackEdge = -1, doneCyc = 0;
  int lat = 0, reqCount = 0;
  logic [1:0] lastOp = '0;
  logic [31:0] lastAddr = '0, lastWdata = '0;
  logic [31:0] mem [256];
  bit finished = 1'b0;

  flash_isp_ctrl dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .cfgBoot(cfgBoot), .runFromLoader(runFromLoader),
    .fetchAddr(fetchAddr), .fetchMapAddr(fetchMapAddr),
    .flReq(flReq), .flOp(flOp), .flAddr(flAddr), .flWdata(flWdata),
    .flAck(flAck), .flRdata(flRdata)
  );

  always #4 clk = ~clk;

  // behavioural flash with fixed acknowledge latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (flAck) ackEdge <= cyc + 1;
    flAck <= 1'b0;
    if (flReq && !flAck) begin
      if (lat == LAT) begin
        lat <= 0;
        flAck <= 1'b1;
        reqCount <= reqCount + 1;
        lastOp <= flOp;
        lastAddr <= flAddr;
        lastWdata <= flWdata;
        case (flOp)
          2'd0: flRdata <= mem[flAddr[9:2]];
          2'd1: mem[flAddr[9:2]] <= flWdata;
          2'd2: for (int i = 0; i < 128; i++) mem[{flAddr[9], i[6:0]}] <= '1;
          default: ;
        endcase
      end else begin
        lat <= lat + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    int n = 0;
    do begin
      busRead(8'h40, v);
      n++;
    end while (v[0] && n < 200);
    doneCyc = cyc;
  endtask

  task automatic startOp(input logic [31:0] a, input logic [5:0] c);
    busWrite(8'h04, a);
    busWrite(8'h0C, {26'd0, c});
    busWrite(8'h10, 32'h1);
    waitIdle();
  endtask

  task automatic expectRefused(input string tag, input logic [31:0] a, input logic [5:0] c);
    logic [31:0] v;
    int rc = reqCount;
    startOp(a, c);
    busRead(8'h00, v); chk({tag, " fail flag ctrl"}, {31'd0, v[6]}, 32'd1);
    busRead(8'h40, v); chk({tag, " fail flag status"}, {31'd0, v[6]}, 32'd1);
    chk({tag, " no flash request"}, reqCount, rc);
    busWrite(8'h40, 32'h40);
    busRead(8'h00, v); chk({tag, " flag cleared"}, {31'd0, v[6]}, 32'd0);
  endtask

  task automatic expectDone(input string tag, input logic [31:0] a, input logic [5:0] c);
    logic [31:0] v;
    int rc = reqCount;
    startOp(a, c);
    busRead(8'h00, v); chk({tag, " no fail"}, {31'd0, v[6]}, 32'd0);
    chk({tag, " flash request made"}, reqCount, rc + 1);
  endtask

  task automatic testReset();
    logic [31:0] v;
    busRead(8'h00, v); chk("R1 ctrl reset", v, 32'h2);
    busRead(8'h10, v); chk("R1 trigger reset", v, 32'h0);
    busRead(8'h40, v); chk("R1 status reset", v, 32'h0);
    busRead(8'h04, v); chk("R1 addr reset", v, 32'h0);
    busRead(8'h08, v); chk("R1 data reset", v, 32'h0);
    busRead(8'h0C, v); chk("R1 cmd reset", v, 32'h0);
  endtask

  task automatic testDisabled();
    logic [31:0] v;
    int rc = reqCount;
    busWrite(8'h10, 32'h1);
    busRead(8'h10, v); chk("R2 trigger ignored", v, 32'h0);
    repeat (LAT + 3) @(negedge clk);
    chk("R2 no request", reqCount, rc);
  endtask

  task automatic testProgRead();
    logic [31:0] v;
    busWrite(8'h00, 32'h39);
    busWrite(8'h08, 32'hA5A5_1234);
    busWrite(8'h04, 32'h100);
    busWrite(8'h0C, 32'h21);
    busWrite(8'h10, 32'h1);
    busRead(8'h10, v); chk("R3 start bit set", v, 32'h1);
    busRead(8'h40, v); chk("R3 status busy mirror", {31'd0, v[0]}, 32'h1);
    waitIdle();
    chk("R3 clear one cycle after ack", doneCyc, ackEdge);
    chk("R4 program op", {30'd0, lastOp}, 32'd1);
    chk("R4 program addr", lastAddr, 32'h100);
    chk("R4 program data", lastWdata, 32'hA5A5_1234);
    busWrite(8'h08, 32'h0);
    startOp(32'h100, 6'h00);
    chk("R4 read op", {30'd0, lastOp}, 32'd0);
    busRead(8'h08, v); chk("R4 read data", v, 32'hA5A5_1234);
  endtask

  task automatic testErase();
    logic [31:0] v;
    startOp(32'h104, 6'h22);
    chk("R5 erase op", {30'd0, lastOp}, 32'd2);
    chk("R5 erase page aligned", lastAddr, 32'h0);
    startOp(32'h100, 6'h00);
    busRead(8'h08, v); chk("R5 erased word", v, 32'hFFFF_FFFF);
  endtask

  task automatic testIds();
    logic [31:0] v;
    int rc = reqCount;
    startOp(32'h0, 6'h0B);
    busRead(8'h08, v); chk("R6 vendor id", v, 32'hDA);
    startOp(32'h0, 6'h04);
    busRead(8'h08, v); chk("R6 unique id", v, UID);
    chk("R6 no flash request", reqCount, rc);
  endtask

  task automatic testAppProtect();
    logic [31:0] v;
    busWrite(8'h00, 32'h31);
    runFromLoader = 1'b0;
    startOp(32'h200, 6'h21);
    busRead(8'h00, v); chk("R11 flag set", {31'd0, v[6]}, 32'd1);
    busRead(8'h10, v); chk("R11 start bit cleared", v, 32'h0);
    busWrite(8'h00, 32'h31);
    busRead(8'h00, v); chk("R11 writing 0 keeps flag", {31'd0, v[6]}, 32'd1);
    busWrite(8'h00, 32'h71);
    busRead(8'h00, v); chk("R11 ctrl write 1 clears", {31'd0, v[6]}, 32'd0);
    expectRefused("R7 app erase no enable", 32'h200, 6'h22);
    runFromLoader = 1'b1;
    expectDone("R7 app from loader", 32'h200, 6'h21);
    runFromLoader = 1'b0;
    busWrite(8'h00, 32'h39);
    expectDone("R7 app enabled", 32'h200, 6'h21);
    cfgBoot = 2'b01;
    expectRefused("R7 app boot lock", 32'h200, 6'h21);
  endtask

  task automatic testLdrCfg();
    runFromLoader = 1'b1;
    cfgBoot = 2'b00;
    busWrite(8'h00, 32'h19);
    expectRefused("R8 loader no enable", 32'h100010, 6'h21);
    busWrite(8'h00, 32'h39);
    expectDone("R8 loader enabled", 32'h100010, 6'h21);
    cfgBoot = 2'b01;
    expectRefused("R8 loader boot lock", 32'h100010, 6'h22);
    cfgBoot = 2'b00;
    runFromLoader = 1'b0;
    busWrite(8'h00, 32'h29);
    expectRefused("R9 config no enable", 32'h300000, 6'h21);
    busWrite(8'h00, 32'h39);
    expectDone("R9 config enabled", 32'h300004, 6'h21);
  endtask

  task automatic testIllegal();
    expectRefused("R10 misaligned read", 32'h102, 6'h00);
    expectRefused("R10 out of range", 32'h2000, 6'h21);
    expectRefused("R10 unknown command", 32'h100, 6'h3F);
  endtask

  task automatic testBusyLock();
    logic [31:0] v;
    busWrite(8'h08, 32'h1111_2222);
    busWrite(8'h04, 32'h108);
    busWrite(8'h0C, 32'h21);
    busWrite(8'h10, 32'h1);
    busWrite(8'h04, 32'h10C);
    busWrite(8'h08, 32'h3333_4444);
    busWrite(8'h0C, 32'h00);
    waitIdle();
    chk("R13 flash addr kept", lastAddr, 32'h108);
    chk("R13 flash data kept", lastWdata, 32'h1111_2222);
    busRead(8'h04, v); chk("R13 addr reg kept", v, 32'h108);
    busRead(8'h08, v); chk("R13 data reg kept", v, 32'h1111_2222);
    busRead(8'h0C, v); chk("R13 cmd reg kept", v, 32'h21);
  endtask

  task automatic testRemap();
    logic [31:0] v;
    int rc = reqCount;
    startOp(32'hA00, 6'h2E);
    chk("R12 no flash request", reqCount, rc);
    busRead(8'h40, v); chk("R12 remap page", {20'd0, v[20:9]}, 32'd5);
    @(negedge clk); fetchAddr = 32'h1F4;
    #1 chk("R12 low page remapped", fetchMapAddr, 32'hBF4);
    fetchAddr = 32'h200;
    #1 chk("R12 upper passes", fetchMapAddr, 32'h200);
    expectRefused("R12 remap out of app", 32'h2000, 6'h2E);
    busRead(8'h40, v); chk("R12 page unchanged", {20'd0, v[20:9]}, 32'd5);
  endtask

  task automatic testReadOnly();
    logic [31:0] v;
    busRead(8'h14, v); chk("R14 data base", v, DBASE);
    busWrite(8'h14, 32'hFFFF_FFFF);
    busRead(8'h14, v); chk("R14 data base write ignored", v, DBASE);
    cfgBoot = 2'b10;
    busRead(8'h40, v); chk("R14 boot mirror", {30'd0, v[2:1]}, 32'd2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDisabled();
    testProgRead();
    testErase();
    testIds();
    testAppProtect();
    testLdrCfg();
    testIllegal();
    testBusyLock();
    testRemap();
    testReadOnly();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule